// File: doc/BRIEF.md
# Cascadable Up/Down Binary Counter Stage

A synchronous binary counter stage, four bits wide by default, that steps up or down on the rising clock edge. Stepping happens only while an active-low enable is held low. The direction comes from a single line. An active-low load presents the data inputs on the count outputs at once, at any clock level, and sets the starting point for counting. Presetting the count this way lets the stage divide the clock by any modulus.

Two outputs support chaining. The first is a terminal flag that is high while the count sits at the wrap point for the current direction. The second is an active-low ripple output that pulses low during the low half of the clock when that flag is set and the stage is enabled. Feeding the ripple output into the next stage's enable, with the clock shared by both stages, gives a wider counter. Enable and direction may only change while the clock is high.

Top module: `updown_stage`

## Requirements
- R1: All count bits change together, only on a rising clock edge. Between edges the count stays constant unless a load is applied.
- R2: While `en_n` is high, rising edges leave the count unchanged.
- R3: With `en_n` low and `dn_up` low, each rising edge adds one, modulo 2^WIDTH, so 15 steps to 0 at the default width.
- R4: With `en_n` low and `dn_up` high, each rising edge subtracts one, modulo 2^WIDTH, so 0 steps to 15 at the default width.
- R5: While `load_n` is low, `count_o` equals `data_i` without waiting for a clock edge, and clock edges do not count. `data_i` must stay stable while `load_n` is low.
- R6: After `load_n` returns high, the first qualifying rising edge counts from the preset value.
- R7: `maxmin_o` is high exactly when `dn_up` is low and the count is all ones, or when `dn_up` is high and the count is zero. The flag does not depend on `en_n`, so it stays high for the whole clock period the count rests there.
- R8: `ripple_n_o` is low exactly when `clk` is low, `maxmin_o` is high and `en_n` is low. Otherwise it is high.
- R9: Two stages, with the low stage's `ripple_n_o` driving the high stage's `en_n`, form an 8-bit counter. That counter steps 254→255→0 counting up and 1→0→255 counting down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock; the rising edge is active |
| en_n | input | 1 | Count enable, active low |
| dn_up | input | 1 | Direction: 0 counts up, 1 counts down |
| load_n | input | 1 | Asynchronous parallel load, active low |
| data_i | input | WIDTH | Preset value |
| count_o | output | WIDTH | Current count |
| maxmin_o | output | 1 | High at the terminal count for the current direction |
| ripple_n_o | output | 1 | Active-low cascade pulse during the clock's low phase |

## Verification
The only state is the count register, and it appears directly on `count_o`. A wrong next-state value therefore shows up at the first sample after the offending edge. A faulty terminal decode appears on `maxmin_o` during the same period. A faulty ripple gate appears in the following low half-cycle. In a chain, a stale or premature ripple shows as a wrong upper byte at the edge that crosses the 255/0 boundary.

// File: rtl/updown_stage.sv
module updown_stage #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             en_n,
  input  logic             dn_up,
  input  logic             load_n,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] count_o,
  output logic             maxmin_o,
  output logic             ripple_n_o
);
  localparam logic [WIDTH-1:0] TOP = '1;

  logic [WIDTH-1:0] q_r;
  logic [WIDTH-1:0] q_nxt;

  assign q_nxt = dn_up ? q_r - 1'b1 : q_r + 1'b1;

  always_ff @(posedge clk or negedge load_n)
    if (!load_n)    q_r <= data_i;
    else if (!en_n) q_r <= q_nxt;

  assign count_o    = load_n ? q_r : data_i;
  assign maxmin_o   = dn_up ? (count_o == '0) : (count_o == TOP);
  assign ripple_n_o = ~(~clk & maxmin_o & ~en_n);
endmodule

module updown_stage_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             en_n,
  input logic             dn_up,
  input logic             load_n,
  input logic [WIDTH-1:0] count_o,
  input logic             maxmin_o,
  input logic             ripple_n_o
);
  assert_hold_R2: assert property (@(posedge clk) disable iff (!load_n)
    (load_n && en_n) |=> $stable(count_o));

  assert_step_up_R3: assert property (@(posedge clk) disable iff (!load_n)
    (load_n && !en_n && !dn_up) |=> count_o == WIDTH'($past(count_o) + 1'b1));

  assert_step_down_R4: assert property (@(posedge clk) disable iff (!load_n)
    (load_n && !en_n && dn_up) |=> count_o == WIDTH'($past(count_o) - 1'b1));

  assert_flag_at_end_R7: assert property (@(posedge clk) disable iff (!load_n)
    maxmin_o |-> (count_o == '0 || count_o == '1));

  assert_ripple_low_R8: assert property (@(posedge clk) disable iff (!load_n)
    (!en_n && maxmin_o) |-> !ripple_n_o);

  assert_ripple_idle_R8: assert property (@(posedge clk) disable iff (!load_n)
    en_n |-> ripple_n_o);
endmodule

bind updown_stage updown_stage_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .en_n(en_n), .dn_up(dn_up), .load_n(load_n),
  .count_o(count_o), .maxmin_o(maxmin_o), .ripple_n_o(ripple_n_o));

// File: tb/tb_updown_stage.sv
module tb_updown_stage;
  logic       clk = 1'b0;
  logic       clk_lag;
  logic       en_n = 1'b1, dn_up = 1'b0, load_n = 1'b0;
  logic [3:0] data = 4'd0;
  logic [3:0] count;
  logic       mm, rip_n;

  logic       c_dn = 1'b0, c_load_n = 1'b0;
  logic [7:0] c_data = 8'd0;
  logic [3:0] lo_q, hi_q;
  logic       lo_mm, lo_rip_n, hi_mm, hi_rip_n;

  int vectors = 0, errors = 0, exp_q = 0, c_exp = 0;
  bit done = 0;

  always #5 clk = ~clk;
  assign #1 clk_lag = clk;

  updown_stage #(.WIDTH(4)) dut (
    .clk(clk), .en_n(en_n), .dn_up(dn_up), .load_n(load_n), .data_i(data),
    .count_o(count), .maxmin_o(mm), .ripple_n_o(rip_n));

  updown_stage #(.WIDTH(4)) u_lo (
    .clk(clk_lag), .en_n(1'b0), .dn_up(c_dn), .load_n(c_load_n), .data_i(c_data[3:0]),
    .count_o(lo_q), .maxmin_o(lo_mm), .ripple_n_o(lo_rip_n));

  updown_stage #(.WIDTH(4)) u_hi (
    .clk(clk), .en_n(lo_rip_n), .dn_up(c_dn), .load_n(c_load_n), .data_i(c_data[7:4]),
    .count_o(hi_q), .maxmin_o(hi_mm), .ripple_n_o(hi_rip_n));

  task automatic chk(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int flag_of(int q, bit dn);
    return dn ? int'(q == 0) : int'(q == 15);
  endfunction

  task automatic preset(int v, bit en_val, bit dir);
    @(posedge clk); #2;
    load_n = 1'b0; data = 4'(v); exp_q = v;
    #1 chk("R5 async load", count, v);
    en_n = en_val; dn_up = dir;
    @(posedge clk); #3;
    chk("R5 load overrides clock", count, v);
    #0 load_n = 1'b1;
  endtask

  task automatic run(int n, string req);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #3;
      if (!en_n) exp_q = dn_up ? (exp_q + 15) % 16 : (exp_q + 1) % 16;
      chk(req, count, exp_q);
      chk("R7 flag", mm, flag_of(exp_q, dn_up));
      @(negedge clk); #1;
      chk("R1 stable between edges", count, exp_q);
      chk("R8 ripple low phase", rip_n, (flag_of(exp_q, dn_up) && !en_n) ? 0 : 1);
    end
  endtask

  task automatic test_reset_load;
    #1 chk("R5 initial load", count, 0);
    @(negedge clk); #1;
    data = 4'd3;
    #1 chk("R5 follows data in low phase", count, 3);
    data = 4'd0;
  endtask

  task automatic test_up;
    preset(13, 1'b0, 1'b0);
    run(5, "R3 R6 up count with wrap");
  endtask

  task automatic test_down;
    preset(2, 1'b0, 1'b1);
    run(5, "R4 R6 down count with wrap");
  endtask

  task automatic test_hold;
    preset(15, 1'b1, 1'b0);
    run(3, "R2 hold while disabled");
    preset(0, 1'b1, 1'b1);
    run(2, "R2 hold at zero");
  endtask

  task automatic cpreset(int v, bit dir);
    @(posedge clk); #2;
    c_load_n = 1'b0; c_data = 8'(v); c_dn = dir; c_exp = v;
    @(posedge clk); #2;
    c_load_n = 1'b1;
  endtask

  task automatic crun(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #4;
      c_exp = c_dn ? (c_exp + 255) % 256 : (c_exp + 1) % 256;
      chk("R9 chain count", {hi_q, lo_q}, c_exp);
    end
  endtask

  task automatic test_chain;
    cpreset(254, 1'b0);
    crun(3);
    cpreset(1, 1'b1);
    crun(3);
    cpreset(15, 1'b0);
    crun(2);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    test_reset_load();
    test_up();
    test_down();
    test_hold();
    test_chain();
    finish_run();
  end
endmodule